// File: doc/BRIEF.md
# Clock Source Selection Controller

This block decides which oscillator drives the system clock. There are three candidates: the main oscillator, a slow sub oscillator, and a PLL that runs at one of four multipliers. Software holds two configuration bits. The main/PLL bit, `mcs_q`, asks for the main clock when set and for the PLL when clear. The main/sub bit, `scs_q`, asks for main-side operation when set and for the sub clock when clear.

A change of source never happens at once. The controller moves through a transitional state and waits there for the event that makes the change safe:

- the PLL stabilization-done pulse,
- the main-oscillator stabilization-done pulse, or
- the PLL/main synchronization strobe.

The analog oscillators, the PLL and the glitch-free clock mux sit outside the block. The controller only drives their select lines and reports status through two flags:

- `scm` is low only while the sub clock alone is in use.
- `mcm` is low whenever the PLL drives the system.

Two kinds of reset are handled. A full reset, such as power-on, sets both configuration bits. A keep reset, which covers the external pin and the software reset bit, leaves both bits as they were. Either kind returns the state machine to the main-clock state. The PLL multiplier code is sampled from `mul_sel` only on the cycle in which a PLL stabilization wait completes.

Top module: `clksel_top`

## Requirements
- R1: A reset with `rst_keep`=0 sets `mcs_q`=1 and `scs_q`=1. It also sets the state to main clock, which shows as `scm`=1, `mcm`=1, `src_sel`=3'b001 and `mul_code`=0. `src_sel` is one-hot: bit0 = main, bit1 = sub, bit2 = PLL.
- R2: A reset with `rst_keep`=1 leaves `mcs_q` and `scs_q` unchanged and returns the state to main clock. From there the controller follows the kept bits.
- R3: In the main state with `scs_q`=1, clearing `mcs_q` moves the controller to main-to-PLL. That state shows `scm`=1, `mcm`=1 and source main.
- R4: In main-to-PLL, a `pll_stab_done` pulse enters the PLL state. The PLL state shows `scm`=1, `mcm`=0 and source PLL. On that edge `mul_code` latches `mul_sel` (00→0 for multiplier 1, 01→1, 10→2, 11→3 for multiplier 4).
- R5: While in the PLL state, changes on `mul_sel` leave `mul_code` unchanged.
- R6: In the PLL state, `mcs_q`=1 or `scs_q`=0 moves the controller to PLL-to-main. That state shows `scm`=1, `mcm`=0, source PLL and the same `mul_code`.
- R7: PLL-to-main leaves only on `sync_tick`. It goes to main if `scs_q`=1 and to main-to-sub if `scs_q`=0.
- R8: Main-to-sub shows `scm`=1, `mcm`=1 and source main, and `sync_tick` moves it to sub. The main state enters main-to-sub whenever `scs_q`=0. The sub state shows `scm`=0, `mcm`=1 and source sub.
- R9: In sub, `scs_q`=1 moves the controller to sub-to-main, which shows `scm`=1, `mcm`=1 and source sub. A `main_stab_done` pulse then goes to main if `mcs_q`=1 and to main-to-PLL if `mcs_q`=0.
- R10: A strobe arriving in a state that is not waiting for it changes neither the state nor the outputs.
- R11: A configuration write takes effect on `mcs_q`/`scs_q` at the edge that samples `cfg_we`. The state and flags react at the following edge and change together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rst_keep | input | 1 | Reset cause: 1 = pin/software reset that keeps the configuration bits |
| cfg_we | input | 1 | Write strobe for the configuration bits |
| cfg_mcs | input | 1 | Write data for the main/PLL bit |
| cfg_scs | input | 1 | Write data for the main/sub bit |
| mul_sel | input | 2 | Requested PLL multiplier code |
| pll_stab_done | input | 1 | PLL stabilization-wait done pulse |
| main_stab_done | input | 1 | Main-oscillator stabilization-wait done pulse |
| sync_tick | input | 1 | PLL/main synchronization timing strobe |
| mcs_q | output | 1 | Main/PLL select bit |
| scs_q | output | 1 | Main/sub select bit |
| scm | output | 1 | Status flag, low only while the sub clock alone is in use |
| mcm | output | 1 | Status flag, low while the PLL drives the system |
| src_sel | output | 3 | One-hot clock source select |
| mul_code | output | 2 | Multiplier code in use |

## Verification
A configuration write shows on `mcs_q`/`scs_q` one edge after it is presented. The resulting state change shows on the flags one edge after that, so a write is followed by two checked cycles: the first still expects the old state and the second expects the new one. A strobe has its effect on the very edge that samples it, so the expectation for that edge is queued together with the strobe. Every expectation is queued before its edge and compared one time unit after that edge, which fixes each comparison to a single known edge.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int SRC_N = 3;

  typedef enum logic [2:0] {
    ST_MAIN,
    ST_M2P,
    ST_PLL,
    ST_P2M,
    ST_M2S,
    ST_SUB,
    ST_S2M
  } clk_state_t;

  typedef struct packed {
    logic             scm;
    logic             mcm;
    logic [SRC_N-1:0] src;
  } clk_flags_t;

  function automatic clk_flags_t flags_of(clk_state_t s);
    clk_flags_t f;
    unique case (s)
      ST_MAIN, ST_M2P, ST_M2S: f = '{scm: 1'b1, mcm: 1'b1, src: 3'b001};
      ST_PLL,  ST_P2M:         f = '{scm: 1'b1, mcm: 1'b0, src: 3'b100};
      ST_SUB:                  f = '{scm: 1'b0, mcm: 1'b1, src: 3'b010};
      ST_S2M:                  f = '{scm: 1'b1, mcm: 1'b1, src: 3'b010};
      default:                 f = '{scm: 1'b1, mcm: 1'b1, src: 3'b001};
    endcase
    return f;
  endfunction
endpackage

// File: rtl/clksel_cfg_reg.sv
module clksel_cfg_reg (
  input  logic clk,
  input  logic rst,
  input  logic rst_keep,
  input  logic we,
  input  logic mcs_d,
  input  logic scs_d,
  output logic mcs_q,
  output logic scs_q
);
  logic started;

  always_ff @(posedge clk) begin
    if (rst) begin
      if (!rst_keep) begin
        mcs_q <= 1'b1;
        scs_q <= 1'b1;
      end
    end else if (we) begin
      mcs_q <= mcs_d;
      scs_q <= scs_d;
    end
  end

  always_ff @(posedge clk) started <= 1'b1;

  // R2: a keep-type reset preserves both bits
  a_r2_keep_bits: assert property (@(posedge clk)
    (started && rst && rst_keep) |=> ($stable(mcs_q) && $stable(scs_q)))
    else $error("a_r2_keep_bits");

  // R1: a full reset sets both bits
  a_r1_full_bits: assert property (@(posedge clk)
    (started && rst && !rst_keep) |=> (mcs_q && scs_q))
    else $error("a_r1_full_bits");
endmodule

// File: rtl/clksel_fsm.sv
module clksel_fsm
  import clksel_pkg::*;
#(
  parameter int MUL_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   mcs,
  input  logic                   scs,
  input  logic [MUL_W-1:0]       mul_sel,
  input  logic                   pll_stab,
  input  logic                   main_stab,
  input  logic                   sync_tick,
  output logic                   scm,
  output logic                   mcm,
  output logic [SRC_N-1:0]       src_sel,
  output logic [MUL_W-1:0]       mul_code
);
  clk_state_t state, state_nx;
  clk_flags_t flags_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_MAIN: begin
        if (!scs)      state_nx = ST_M2S;
        else if (!mcs) state_nx = ST_M2P;
      end
      ST_M2P:  if (pll_stab)  state_nx = ST_PLL;
      ST_PLL:  if (mcs || !scs) state_nx = ST_P2M;
      ST_P2M:  if (sync_tick) state_nx = scs ? ST_MAIN : ST_M2S;
      ST_M2S:  if (sync_tick) state_nx = ST_SUB;
      ST_SUB:  if (scs)       state_nx = ST_S2M;
      ST_S2M:  if (main_stab) state_nx = mcs ? ST_MAIN : ST_M2P;
      default: state_nx = ST_MAIN;
    endcase
  end

  assign flags_nx = flags_of(state_nx);

  // R11: state and flags registered on the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_MAIN;
      scm      <= 1'b1;
      mcm      <= 1'b1;
      src_sel  <= 3'b001;
      mul_code <= '0;
    end else begin
      state   <= state_nx;
      scm     <= flags_nx.scm;
      mcm     <= flags_nx.mcm;
      src_sel <= flags_nx.src;
      if (state == ST_M2P && pll_stab) mul_code <= mul_sel;
    end
  end

  // R11: exactly one source selected
  a_r11_src_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot(src_sel))
    else $error("a_r11_src_onehot");

  // R4: PLL as source implies mcm low
  a_r4_pll_mcm: assert property (@(posedge clk) disable iff (rst)
    src_sel[2] |-> (!mcm && scm))
    else $error("a_r4_pll_mcm");

  // R5: multiplier code held while PLL remains selected
  a_r5_mul_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PLL) |=> $stable(mul_code))
    else $error("a_r5_mul_hold");

  // R10: strobes do not move a settled main state
  a_r10_main_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MAIN && mcs && scs) |=> (state == ST_MAIN))
    else $error("a_r10_main_idle");

  // R7: PLL-to-main waits for the synchronization strobe
  a_r7_p2m_wait: assert property (@(posedge clk) disable iff (rst)
    (state == ST_P2M && !sync_tick) |=> (state == ST_P2M))
    else $error("a_r7_p2m_wait");

  // R8: scm low only with the sub clock selected
  a_r8_sub_flag: assert property (@(posedge clk) disable iff (rst)
    !scm |-> (src_sel[1] && mcm))
    else $error("a_r8_sub_flag");
endmodule

// File: rtl/clksel_top.sv
module clksel_top
  import clksel_pkg::*;
#(
  parameter int MUL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_keep,
  input  logic             cfg_we,
  input  logic             cfg_mcs,
  input  logic             cfg_scs,
  input  logic [MUL_W-1:0] mul_sel,
  input  logic             pll_stab_done,
  input  logic             main_stab_done,
  input  logic             sync_tick,
  output logic             mcs_q,
  output logic             scs_q,
  output logic             scm,
  output logic             mcm,
  output logic [SRC_N-1:0] src_sel,
  output logic [MUL_W-1:0] mul_code
);
  clksel_cfg_reg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .rst_keep (rst_keep),
    .we       (cfg_we),
    .mcs_d    (cfg_mcs),
    .scs_d    (cfg_scs),
    .mcs_q    (mcs_q),
    .scs_q    (scs_q)
  );

  clksel_fsm #(.MUL_W(MUL_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .mcs       (mcs_q),
    .scs       (scs_q),
    .mul_sel   (mul_sel),
    .pll_stab  (pll_stab_done),
    .main_stab (main_stab_done),
    .sync_tick (sync_tick),
    .scm       (scm),
    .mcm       (mcm),
    .src_sel   (src_sel),
    .mul_code  (mul_code)
  );
endmodule

// File: tb/clksel_top_tb.sv
module clksel_top_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1, rst_keep = 1'b0, cfg_we = 1'b0, cfg_mcs = 1'b1, cfg_scs = 1'b1;
  logic [1:0] mul_sel = 2'b00;
  logic pll_stab_done = 1'b0, main_stab_done = 1'b0, sync_tick = 1'b0;
  logic mcs_q, scs_q, scm, mcm;
  logic [2:0] src_sel;
  logic [1:0] mul_code;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [8:0] val;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  clksel_top u_dut (
    .clk(clk), .rst(rst), .rst_keep(rst_keep), .cfg_we(cfg_we),
    .cfg_mcs(cfg_mcs), .cfg_scs(cfg_scs), .mul_sel(mul_sel),
    .pll_stab_done(pll_stab_done), .main_stab_done(main_stab_done),
    .sync_tick(sync_tick), .mcs_q(mcs_q), .scs_q(scs_q), .scm(scm),
    .mcm(mcm), .src_sel(src_sel), .mul_code(mul_code)
  );

  // monitor: compare one time unit after each edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      logic [8:0] act;
      e   = sb_q.pop_front();
      act = {mcs_q, scs_q, scm, mcm, src_sel, mul_code};
      n_checks++;
      if (act !== e.val) begin
        n_errors++;
        $display("FAIL %s: actual mcs,scs,scm,mcm,src,mul=%b expected %b", e.tag, act, e.val);
      end
    end
  end

  // driver: push the expectation for the coming edge, then wait for it
  task automatic step(input string tag, input bit chk, input logic bm, input logic bs,
                      input logic fs, input logic fm, input logic [2:0] src,
                      input logic [1:0] mul);
    if (chk) sb_q.push_back('{tag, {bm, bs, fs, fm, src, mul}});
    @(posedge clk);
    #2;
    cfg_we = 1'b0; pll_stab_done = 1'b0; main_stab_done = 1'b0; sync_tick = 1'b0;
  endtask

  task automatic wr(input logic m, input logic s);
    cfg_we = 1'b1; cfg_mcs = m; cfg_scs = s;
  endtask

  localparam logic [2:0] MN = 3'b001, SB = 3'b010, PL = 3'b100;

  initial begin
    @(negedge clk);
    rst = 1'b1; rst_keep = 1'b0;
    step("R1 full reset", 1, 1,1, 1,1, MN, 2'd0);
    rst = 1'b0;
    pll_stab_done = 1; main_stab_done = 1; sync_tick = 1;
    step("R10 strobes in main", 1, 1,1, 1,1, MN, 2'd0);
    wr(0, 1);
    step("R11 bit first", 1, 0,1, 1,1, MN, 2'd0);
    step("R3 main to pll wait", 1, 0,1, 1,1, MN, 2'd0);
    sync_tick = 1; main_stab_done = 1;
    step("R10 strobes in m2p", 1, 0,1, 1,1, MN, 2'd0);
    mul_sel = 2'b10; pll_stab_done = 1;
    step("R4 pll x3", 1, 0,1, 1,0, PL, 2'd2);
    mul_sel = 2'b01;
    step("R5 mul held", 1, 0,1, 1,0, PL, 2'd2);
    pll_stab_done = 1;
    step("R10 pll strobe in pll", 1, 0,1, 1,0, PL, 2'd2);
    wr(1, 1);
    step("R11 pll bits", 1, 1,1, 1,0, PL, 2'd2);
    step("R6 pll to main", 1, 1,1, 1,0, PL, 2'd2);
    step("R7 wait sync", 1, 1,1, 1,0, PL, 2'd2);
    sync_tick = 1;
    step("R7 sync to main", 1, 1,1, 1,1, MN, 2'd2);
    wr(0, 1);
    step("R3 write", 0, 0,1, 1,1, MN, 2'd2);
    step("R3 m2p again", 1, 0,1, 1,1, MN, 2'd2);
    mul_sel = 2'b11; pll_stab_done = 1;
    step("R4 pll x4", 1, 0,1, 1,0, PL, 2'd3);
    wr(0, 0);
    step("R6 write", 0, 0,0, 1,0, PL, 2'd3);
    step("R6 scs clear p2m", 1, 0,0, 1,0, PL, 2'd3);
    sync_tick = 1;
    step("R7 sync to m2s", 1, 0,0, 1,1, MN, 2'd3);
    pll_stab_done = 1; main_stab_done = 1;
    step("R10 strobes in m2s", 1, 0,0, 1,1, MN, 2'd3);
    sync_tick = 1;
    step("R8 enter sub", 1, 0,0, 0,1, SB, 2'd3);
    sync_tick = 1; pll_stab_done = 1; main_stab_done = 1;
    step("R10 strobes in sub", 1, 0,0, 0,1, SB, 2'd3);
    wr(1, 1);
    step("R9 write", 0, 1,1, 0,1, SB, 2'd3);
    step("R9 sub to main wait", 1, 1,1, 1,1, SB, 2'd3);
    sync_tick = 1;
    step("R10 sync in s2m", 1, 1,1, 1,1, SB, 2'd3);
    main_stab_done = 1;
    step("R9 back to main", 1, 1,1, 1,1, MN, 2'd3);
    wr(0, 0);
    step("R8 write", 0, 0,0, 1,1, MN, 2'd3);
    step("R8 main to m2s", 1, 0,0, 1,1, MN, 2'd3);
    sync_tick = 1;
    step("R8 sub again", 1, 0,0, 0,1, SB, 2'd3);
    wr(0, 1);
    step("R9 write2", 0, 0,1, 0,1, SB, 2'd3);
    step("R9 s2m", 1, 0,1, 1,1, SB, 2'd3);
    main_stab_done = 1;
    step("R9 to m2p when mcs 0", 1, 0,1, 1,1, MN, 2'd3);
    mul_sel = 2'b00; pll_stab_done = 1;
    step("R4 pll x1", 1, 0,1, 1,0, PL, 2'd0);
    rst = 1'b1; rst_keep = 1'b1;
    step("R2 keep reset", 1, 0,1, 1,1, MN, 2'd0);
    rst = 1'b0; rst_keep = 1'b0;
    step("R2 follows kept bits", 1, 0,1, 1,1, MN, 2'd0);
    mul_sel = 2'b01; pll_stab_done = 1;
    step("R4 pll x2", 1, 0,1, 1,0, PL, 2'd1);
    rst = 1'b1;
    step("R1 full reset again", 1, 1,1, 1,1, MN, 2'd0);
    rst = 1'b0;
    step("R1 stays main", 1, 1,1, 1,1, MN, 2'd0);
    step("drain", 0, 1,1, 1,1, MN, 2'd0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule